// File: doc/BRIEF.md
# Reloadable Interval Countdown Timer

This block is a down-counter that measures intervals in time-base ticks. A single-cycle `tick` enable sets the rate, and the counter moves only on cycles where `tick` is high. Software writes a value through a one-word write port. A nonzero value starts a countdown from that value at once. A zero value halts the counter. Each write also stores the value as the restart interval, and the live count is visible at all times on `count`.

The interval elapses on the tick that takes the count from 1 to 0. On that tick the block emits a one-cycle expiry strobe, which a separate status register uses to set its sticky flag. If the interrupt enable is high, it also emits a one-cycle interrupt request. With the auto-restart control high, the counter reloads the stored interval and keeps running. With it low, the counter stays at zero until the next write.

Top module: `interval_countdown`

## Requirements
- R1: Every write, zero or nonzero, replaces the stored restart interval with `wr_data`. The value in use for restarts is always that of the most recent write.
- R2: A write of zero makes `count` 0 on the next cycle. After that, no tick produces an expiry strobe or an interrupt request until a nonzero write occurs.
- R3: A nonzero write makes `count` equal `wr_data` on the next cycle, whatever the state of `tick`. After that, `count` drops by exactly one on each clock edge where `tick` is 1, and holds on edges where `tick` is 0.
- R4: On the clock edge where `tick` is 1 and `count` is 1, `status_set` goes high for one cycle. It rises in the same cycle that `count` shows its post-expiry value, and it is low in every other case.
- R5: `irq_req` goes high in exactly the cycles where `status_set` is high and `irq_enable` was 1 on the expiring edge. It stays low at expiry when `irq_enable` was 0.
- R6: When `auto_restart` is 1 on the expiring edge, `count` takes the stored interval. When it is 0, `count` becomes 0 and stays 0 through later ticks.
- R7: An interval never resolves to zero ticks. A write of 1 expires on the very next tick. With `auto_restart` at 1, it then expires on every tick and holds `count` at 1.
- R8: A write on the same edge as an expiry wins over the restart, so `count` takes `wr_data`. The expiry strobe, and the interrupt request if enabled, are still issued.
- R9: After reset, `count`, `status_set` and `irq_req` are 0, the stored interval is 0, and ticks cause no expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time-base enable; one count step per high cycle |
| wr_en | input | 1 | Write strobe for the interval value |
| wr_data | input | CNT_W | Interval value to write; 0 means stop |
| auto_restart | input | 1 | Restart from stored interval after expiry |
| irq_enable | input | 1 | Allow an interrupt request on expiry |
| count | output | CNT_W | Live remaining count |
| status_set | output | 1 | One-cycle expiry strobe for the status flag |
| irq_req | output | 1 | One-cycle interrupt request |

## Verification
The in-line properties check the cycle-level rules on every cycle. These cover how a write loads the counter and the stored interval, the single decrement per tick, a stopped counter holding zero, and the restart value never being zero. They also check that an interrupt request never appears without an expiry strobe, and that every strobe follows a tick that found the count at 1. The directed scenarios are needed for the end-to-end sequences. These include repeated auto-restart periods, the one-tick interval firing back to back, a zero write leaving the counter silent over many ticks, and a write that lands on the expiring edge.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // Action taken by the down-counter on a given clock edge.
    typedef enum logic [2:0] {
        ACT_HOLD   = 3'd0,
        ACT_LOAD   = 3'd1,
        ACT_DEC    = 3'd2,
        ACT_RELOAD = 3'd3,
        ACT_STOP   = 3'd4
    } cnt_action_e;

endpackage

// File: rtl/pit_reload_reg.sv
module pit_reload_reg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] reload_q
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
    } rl_state_t;

    rl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.value = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reload_q = state_q.value;

    // R1: every write lands in the stored interval
    p_write_stores_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reload_q == $past(wr_data)));

    // R1: without a write the stored interval is unchanged
    p_reload_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reload_q));

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
    import pit_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t  state_d, state_q;
    cnt_action_e act;

    // Expiry: a tick that finds the count at one.
    always_comb begin
        expire = tick && (state_q.count == CNT_ONE);
    end

    // Write beats restart; restart/stop beats plain decrement.
    always_comb begin
        if (load_en) begin
            act = ACT_LOAD;
        end else if (expire) begin
            act = reload_en ? ACT_RELOAD : ACT_STOP;
        end else if (tick && (state_q.count != '0)) begin
            act = ACT_DEC;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (act)
            ACT_LOAD:   state_d.count = load_val;
            ACT_RELOAD: state_d.count = reload_val;
            ACT_STOP:   state_d.count = '0;
            ACT_DEC:    state_d.count = state_q.count - CNT_ONE;
            default:    state_d.count = state_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_q = state_q.count;

    // R3: a write sets the count regardless of tick
    p_load_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count_q == $past(load_val)));

    // R3: one step per tick above one
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && (count_q > CNT_ONE)) |=> (count_q == $past(count_q) - CNT_ONE));

    // R3: no tick, no write, no movement
    p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(count_q));

    // R2/R6: a stopped counter stays at zero until written
    p_stopped_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q == '0) && !load_en) |=> (count_q == '0));

    // R6: expiry without restart and without write ends at zero
    p_stop_after_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load_en && !reload_en) |=> (count_q == '0));

    // R6: expiry with restart takes the stored interval
    p_restart_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load_en && reload_en) |=> (count_q == $past(reload_val)));

endmodule

// File: rtl/pit_event_out.sv
module pit_event_out (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    output logic status_q,
    output logic irq_q
);

    typedef struct packed {
        logic status;
        logic irq;
    } ev_state_t;

    ev_state_t state_d, state_q;

    always_comb begin
        state_d.status = expire;
        state_d.irq    = expire && irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_q = state_q.status;
    assign irq_q    = state_q.irq;

    // R5: a request never appears without the expiry strobe
    p_irq_needs_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> status_q);

    // R5: a disabled enable at expiry suppresses the request
    p_irq_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !irq_en) |=> !irq_q);

endmodule

// File: rtl/interval_countdown.sv
module interval_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             auto_restart,
    input  logic             irq_enable,
    output logic [CNT_W-1:0] count,
    output logic             status_set,
    output logic             irq_req
);

    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] reload_val;
    logic             expire;

    pit_reload_reg #(.CNT_W(CNT_W)) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .reload_q (reload_val)
    );

    pit_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load_en    (wr_en),
        .load_val   (wr_data),
        .reload_en  (auto_restart),
        .reload_val (reload_val),
        .count_q    (count),
        .expire     (expire)
    );

    pit_event_out u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .irq_en   (irq_enable),
        .status_q (status_set),
        .irq_q    (irq_req)
    );

    // R7: a restart never begins a zero-length interval
    p_interval_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && auto_restart && !wr_en) |-> (reload_val != '0));

    // R4: every strobe follows a tick that found the count at one
    p_strobe_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_set |-> ($past(tick) && ($past(count) == CNT_ONE)));

    // R8: a write on the expiring edge wins over the restart
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && wr_en) |=> ((count == $past(wr_data)) && status_set));

endmodule

// File: tb/sim_interval_countdown.sv
`timescale 1ns/1ps
module sim_interval_countdown;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         auto_restart = 1'b0;
    logic         irq_enable = 1'b0;
    logic [W-1:0] count;
    logic         status_set;
    logic         irq_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    interval_countdown #(.CNT_W(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .auto_restart (auto_restart),
        .irq_enable   (irq_enable),
        .count        (count),
        .status_set   (status_set),
        .irq_req      (irq_req)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input longint c,
                           input bit st, input bit ir);
        chk(req, "count", count, c);
        chk(req, "status_set", status_set, st);
        chk(req, "irq_req", irq_req, ir);
    endtask

    // One clock with the given tick level; outputs sampled at the next negedge.
    task automatic step(input bit t);
        tick = t;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic write(input logic [W-1:0] v, input bit t);
        wr_en = 1'b1;
        wr_data = v;
        tick = t;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        tick = 1'b0;
    endtask

    task automatic t_reset();
        chk_out("R9", 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1'b1);
        chk_out("R9", 0, 0, 0);
    endtask

    task automatic t_load_and_count();
        write(32'd5, 1'b1);
        chk("R3", "count after write", count, 5);
        for (int i = 0; i < 3; i++) step(1'b0);
        chk("R3", "hold without tick", count, 5);
        step(1'b1);
        step(1'b1);
        chk("R3", "two ticks", count, 3);
    endtask

    task automatic t_expire_irq();
        irq_enable = 1'b1;
        auto_restart = 1'b0;
        step(1'b1);
        chk_out("R3", 2, 0, 0);
        step(1'b1);
        chk_out("R4", 1, 0, 0);
        step(1'b1);
        chk_out("R4", 0, 1, 1);
        step(1'b0);
        chk_out("R4", 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step(1'b1);
            chk_out("R6", 0, 0, 0);
        end
    endtask

    task automatic t_no_irq();
        irq_enable = 1'b0;
        write(32'd2, 1'b0);
        step(1'b1);
        step(1'b1);
        chk_out("R5", 0, 1, 0);
        irq_enable = 1'b1;
    endtask

    task automatic t_auto_restart();
        auto_restart = 1'b1;
        write(32'd3, 1'b0);
        for (int p = 0; p < 2; p++) begin
            step(1'b1);
            chk_out("R6", 2, 0, 0);
            step(1'b1);
            chk_out("R6", 1, 0, 0);
            step(1'b1);
            chk_out("R1", 3, 1, 1);
        end
        write(32'd4, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1);
        chk_out("R1", 4, 1, 1);
    endtask

    task automatic t_one_tick();
        auto_restart = 1'b1;
        write(32'd1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            step(1'b1);
            chk_out("R7", 1, 1, 1);
        end
        auto_restart = 1'b0;
        step(1'b1);
        chk_out("R7", 0, 1, 1);
        step(1'b1);
        chk_out("R7", 0, 0, 0);
    endtask

    task automatic t_zero_stop();
        auto_restart = 1'b1;
        write(32'd4, 1'b0);
        step(1'b1);
        chk("R2", "count before stop", count, 3);
        write(32'd0, 1'b1);
        chk_out("R2", 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            step(1'b1);
            chk_out("R2", 0, 0, 0);
        end
    endtask

    task automatic t_write_priority();
        auto_restart = 1'b1;
        irq_enable = 1'b1;
        write(32'd2, 1'b0);
        step(1'b1);
        chk("R8", "count before collision", count, 1);
        write(32'd7, 1'b1);
        chk_out("R8", 7, 1, 1);
        step(1'b1);
        chk_out("R8", 6, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_count();
        t_expire_irq();
        t_no_irq();
        t_auto_restart();
        t_one_tick();
        t_zero_stop();
        t_write_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule